// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst to a synchronous memory. A burst begins when either of two start strobes is high at a rising clock edge. One strobe serves a processor and the other a memory controller. On that edge the block captures the full external word address. The upper bits are held fixed for the rest of the burst. The lowest two bits come from the captured low bits combined with a 2-bit beat counter.

Each edge with the step input high advances the counter by one beat. The counter wraps after four beats. A mode input selects how the counter combines with the captured low bits. In interleaved order the two values are XORed. In linear order they are added modulo four. The array address is driven combinationally from the registered state, so the result of an edge is visible on the output just after that edge.

Top module: `bseq_top`

## Requirements
- R1: While `rst_n` is low the beat counter and the captured address are cleared. `arr_addr` reads zero, even if a strobe is high during reset.
- R2: At an edge where `cpu_start` or `ctl_start` is high, the block captures `ext_addr` and resets the beat count to 0. From that edge on, `arr_addr` equals the captured address.
- R3: At an edge where neither strobe nor `step` is high, the beat count holds. `arr_addr` keeps its value.
- R4: When `order_lin` is 0 (interleaved), `arr_addr[1:0]` equals the captured low bits XOR the beat count.
- R5: When `order_lin` is 1 (linear), `arr_addr[1:0]` equals the captured low bits plus the beat count, modulo 4.
- R6: The beat count is 2 bits and wraps. After four steps with no strobe, `arr_addr` is back at the captured address.
- R7: Bits `arr_addr[AW-1:2]` stay at their captured value at every edge without a strobe.
- R8: A strobe at the same edge as `step` takes priority. The address is reloaded and the beat count becomes 0, not 1.
- R9: A change on `ext_addr` at an edge without a strobe has no effect on `arr_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_start | input | 1 | Processor burst start strobe |
| ctl_start | input | 1 | Controller burst start strobe |
| step | input | 1 | Advance the burst by one beat |
| order_lin | input | 1 | Burst order: 0 = interleaved, 1 = linear |
| ext_addr | input | AW | External word address captured on a strobe |
| arr_addr | output | AW | Current array word address |

## Verification
Every result appears one clock edge after the stimulus that causes it. A strobe shows the captured address, and a step shows the next beat's address. No further register lies on the path to `arr_addr`.

The bench drives its inputs one nanosecond after a rising edge. It waits for the next rising edge and samples one nanosecond later, so each check reads the value that edge produced. It also samples after idle edges, to confirm the address holds.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Burst order selected by the static mode input
    typedef enum logic {
        ORD_XOR = 1'b0,   // interleaved: low bits = start ^ beat
        ORD_SEQ = 1'b1    // linear: low bits = start + beat (mod burst length)
    } order_e;

    // Number of beats in one burst; the counter width is derived from it
    localparam int unsigned BURST_BEATS = 4;

endpackage

// File: rtl/bseq_counter.sv
module bseq_counter #(
    parameter  int unsigned BEATS = bseq_pkg::BURST_BEATS,
    localparam int unsigned CW    = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    output logic [CW-1:0] beat_o
);

    typedef struct packed {
        logic [CW-1:0] beat;
    } cnt_t;

    cnt_t st_d, st_q;

    // Load clears the count and wins over step; the count wraps naturally
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.beat = '0;
        end else if (step) begin
            st_d.beat = st_q.beat + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;

endmodule

// File: rtl/bseq_base.sv
module bseq_base #(
    parameter  int unsigned AW = 17,
    parameter  int unsigned CW = 2,
    localparam int unsigned UW = AW - CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ext_addr,
    output logic [UW-1:0] upper_o,
    output logic [CW-1:0] start_lo_o
);

    typedef struct packed {
        logic [UW-1:0] upper;
        logic [CW-1:0] start_lo;
    } base_t;

    base_t st_d, st_q;

    // Captured address is only replaced by a start strobe
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.upper    = ext_addr[AW-1:CW];
            st_d.start_lo = ext_addr[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_o    = st_q.upper;
    assign start_lo_o = st_q.start_lo;

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import bseq_pkg::*;
#(
    parameter int unsigned CW = 2
) (
    input  order_e        mode,
    input  logic [CW-1:0] start_lo,
    input  logic [CW-1:0] beat,
    output logic [CW-1:0] lo_o
);

    logic [CW-1:0] xor_lo;
    logic [CW-1:0] seq_lo;

    // Interleaved order: each low bit flips independently with the beat count
    for (genvar i = 0; i < CW; i++) begin : g_xor_bit
        assign xor_lo[i] = start_lo[i] ^ beat[i];
    end

    // Linear order: modular add, wraps within the burst window
    assign seq_lo = start_lo + beat;

    always_comb begin
        unique case (mode)
            ORD_SEQ: lo_o = seq_lo;
            default: lo_o = xor_lo;
        endcase
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter  int unsigned AW = 17,
    localparam int unsigned CW = $clog2(BURST_BEATS),
    localparam int unsigned UW = AW - CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_start,
    input  logic          ctl_start,
    input  logic          step,
    input  logic          order_lin,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] arr_addr
);

    logic          any_start;
    logic [CW-1:0] beat_q;
    logic [UW-1:0] upper_q;
    logic [CW-1:0] start_lo_q;
    logic [CW-1:0] lo_bits;
    order_e        mode;

    assign any_start = cpu_start | ctl_start;
    assign mode      = order_e'(order_lin);

    bseq_counter #(
        .BEATS (BURST_BEATS)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (any_start),
        .step   (step),
        .beat_o (beat_q)
    );

    bseq_base #(
        .AW (AW),
        .CW (CW)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (any_start),
        .ext_addr   (ext_addr),
        .upper_o    (upper_q),
        .start_lo_o (start_lo_q)
    );

    bseq_order #(
        .CW (CW)
    ) u_order (
        .mode     (mode),
        .start_lo (start_lo_q),
        .beat     (beat_q),
        .lo_o     (lo_bits)
    );

    assign arr_addr = {upper_q, lo_bits};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int unsigned AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_start,
    input logic          ctl_start,
    input logic          step,
    input logic          order_lin,
    input logic [AW-1:0] ext_addr,
    input logic [AW-1:0] arr_addr,
    input logic [1:0]    beat_q
);

    logic go;
    assign go = cpu_start | ctl_start;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> arr_addr == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> arr_addr == $past(ext_addr));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !step) |=> $stable(beat_q));

    // R4
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && step && !order_lin) |=> order_lin ||
        ((arr_addr[1:0] ^ $past(arr_addr[1:0])) ==
         ($past(beat_q) ^ 2'($past(beat_q) + 2'd1))));

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && step && order_lin) |=> !order_lin ||
        (arr_addr[1:0] == 2'($past(arr_addr[1:0]) + 2'd1)));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && step && beat_q == 2'd3) |=> beat_q == 2'd0);

    // R7
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(arr_addr[AW-1:2]));

    // R8
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && step) |=> beat_q == 2'd0);

endmodule

bind bseq_top bseq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_start (cpu_start),
    .ctl_start (ctl_start),
    .step      (step),
    .order_lin (order_lin),
    .ext_addr  (ext_addr),
    .arr_addr  (arr_addr),
    .beat_q    (beat_q)
);

// File: tb/tb_bseq_top.sv
module tb_bseq_top;

    localparam int unsigned AW = 17;

    logic          clk       = 1'b0;
    logic          rst_n     = 1'b0;
    logic          cpu_start = 1'b0;
    logic          ctl_start = 1'b0;
    logic          step      = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] ext_addr  = '0;
    logic [AW-1:0] arr_addr;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bseq_top #(.AW(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_start (cpu_start),
        .ctl_start (ctl_start),
        .step      (step),
        .order_lin (order_lin),
        .ext_addr  (ext_addr),
        .arr_addr  (arr_addr)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [AW-1:0] exp);
        checks++;
        if (arr_addr !== exp) begin
            errs++;
            $display("FAIL %s: arr_addr=%h expected %h", req, arr_addr, exp);
        end
    endtask

    function automatic logic [1:0] exp_lo(input bit lin, input int s, input int n);
        if (lin) return 2'((s + n) % 4);
        return 2'(s ^ n);
    endfunction

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] nb;
        logic [AW-3:0] up;

        // R1: reset clears, strobe during reset ignored
        cyc();
        chk("R1", '0);
        cpu_start = 1'b1;
        ext_addr  = 17'h1ABCD;
        cyc();
        chk("R1", '0);
        cpu_start = 1'b0;
        rst_n     = 1'b1;
        cyc();
        chk("R1", '0);

        // Sweep every mode, start offset and strobe source
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int src = 0; src < 2; src++) begin
                    up        = (AW-2)'(((m * 8 + s * 2 + src) * 2731 + 5));
                    base      = {up, 2'(s)};
                    order_lin = m[0];
                    ext_addr  = base;
                    if (src == 0) cpu_start = 1'b1;
                    else          ctl_start = 1'b1;
                    cyc();
                    cpu_start = 1'b0;
                    ctl_start = 1'b0;
                    chk("R2", base);
                    // R9: address bus changes without a strobe
                    ext_addr = ~base;
                    for (int n = 1; n <= 4; n++) begin
                        step = 1'b1;
                        cyc();
                        step = 1'b0;
                        if (n == 4)      chk("R6 R7", base);
                        else if (m == 1) chk("R5 R7 R9", {up, exp_lo(1'b1, s, n)});
                        else             chk("R4 R7 R9", {up, exp_lo(1'b0, s, n)});
                        ext_addr = ext_addr + 17'h00111;
                        cyc();
                        chk("R3", {up, exp_lo(m[0], s, n % 4)});
                    end
                end
            end
        end

        // R8: strobe together with step reloads with beat zero
        order_lin = 1'b1;
        base      = 17'h0F0F1;
        ext_addr  = base;
        cpu_start = 1'b1;
        cyc();
        cpu_start = 1'b0;
        step      = 1'b1;
        cyc();
        cyc();
        chk("R5", {base[AW-1:2], 2'd3});
        nb        = 17'h12342;
        ext_addr  = nb;
        ctl_start = 1'b1;
        cyc();
        ctl_start = 1'b0;
        step      = 1'b0;
        chk("R8", nb);
        step = 1'b1;
        cyc();
        step = 1'b0;
        chk("R8", {nb[AW-1:2], 2'd3});

        // R8 in interleaved order as well
        order_lin = 1'b0;
        base      = 17'h00007;
        ext_addr  = base;
        cpu_start = 1'b1;
        step      = 1'b1;
        cyc();
        cpu_start = 1'b0;
        step      = 1'b0;
        chk("R8", base);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule